// File: doc/BRIEF.md
# RTC Serial Command Decoder

This block is the serial front end of a real-time-clock peripheral. It runs on the system clock and oversamples a mode-0 SPI slave link made of chip select (active low), serial clock, data in and data out. After chip select falls, the first eight bits form a command byte. The block decodes that byte into a direction, a target space (clock/control registers or scratch RAM) and a five-bit index. It then moves one byte or a burst of bytes between the link and either an external register port or an internal 31-byte scratch RAM.

The timekeeping counters and their time-set buffer sit outside the block. They are reached through a register port that has a combinational read index with read data, and a registered one-cycle write strobe with index and data. A clock burst write collects all eight bytes locally. Only after chip select rises, and only if all eight arrived whole, does it release them as eight write strobes on consecutive cycles. A RAM burst write stores each byte as soon as it is complete. The block keeps its own copy of the write-protect flag, which is bit 7 of the control register (index 7).

Top module: `rtc_spi_regport`

## Requirements
- R1: A command byte is taken MSB first. Bit 7 is the direction (0 write, 1 read), bit 6 the space (0 clock/control registers, 1 scratch RAM) and bits 5..1 the index. A single write to register space with index below 31 gives exactly one reg_we pulse carrying that index and the data byte.
- R2: A single read (index below 31) presents the addressed byte on miso MSB first, starting at the falling edge that follows the command's eighth rising edge. The byte comes from reg_rdata at reg_rd_idx for register space, or from the scratch RAM for RAM space. Any further bytes read as zero.
- R3: If command bit 0 is 0, nothing is written: no register strobe and no RAM change.
- R4: Index 31 in register space is the clock burst (3Fh write, BFh read), which covers indices 0 to 7 in order. A read returns those eight bytes and then zeros. A write issues eight strobes, index 0 to 7, on consecutive cycles after chip select rises, and only if at least eight whole data bytes were received. Otherwise it issues none.
- R5: Index 31 in RAM space is the RAM burst (7Fh write, FFh read), starting at RAM byte 0. In a burst write every complete byte is stored, and a trailing partial byte is discarded.
- R6: A RAM burst read returns RAM bytes 0 to 30 in order and then zeros.
- R7: Writing register index 7 loads write-protect from data bit 7. While write-protect is set, only writes to register index 7 take effect. Other register writes and all RAM writes are dropped. In a protected clock burst, only index 7 is written.
- R8: miso_en is high only while a read command is shifting data out. It is low whenever chip select is high and throughout write transactions.
- R9: byte_done pulses for one cycle once for each complete byte received, the command byte included. Partial bytes do not pulse.
- R10: After reset, miso_en, reg_we and byte_done are low and write-protect is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, oversampled |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, high impedance when not driven |
| miso_en | output | 1 | Output enable for miso |
| reg_rd_idx | output | 5 | Register index being read |
| reg_rdata | input | 8 | Register data for reg_rd_idx |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wr_idx | output | 5 | Register write index |
| reg_wdata | output | 8 | Register write data |
| byte_done | output | 1 | Pulse per completed received byte |

## Verification
A corrupted command register or byte counter shows up within the next byte. A read returns data from the wrong index, a burst ends early or late, or a stray write strobe appears, and the byte-wise comparison of miso and the strobe count per transaction catches it. A stale write-protect flag shows as an extra or missing write strobe on the very next protected write. A bad clock-burst buffer shows as wrong register contents a few cycles after chip select rises. Output-enable mistakes are checked on every idle clock.

// File: rtl/rtc_spi_regport.sv
module rtc_spi_regport #(
  parameter int RAM_BYTES = 31,
  parameter int CLK_BURST = 8,
  parameter int CTRL_IDX  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_en,
  output logic [4:0] reg_rd_idx,
  input  logic [7:0] reg_rdata,
  output logic       reg_we,
  output logic [4:0] reg_wr_idx,
  output logic [7:0] reg_wdata,
  output logic       byte_done
);
  localparam int CW = $clog2(CLK_BURST);
  localparam int NW = 6;
  localparam logic [4:0] BURST_IDX = 5'd31;

  logic [2:0] cs_p, sck_p;
  logic [1:0] mo_p;
  logic [2:0] bcnt;
  logic [6:0] sh;
  logic [7:0] cmd, tx;
  logic [NW-1:0] nbytes;
  logic have_cmd, load, skip, tx_on, wp, rp_on;
  logic [CW-1:0] rp_idx;
  logic [7:0] ram  [RAM_BYTES];
  logic [7:0] cbuf [CLK_BURST];

  wire active   = ~cs_p[1];
  wire sck_rise = sck_p[1] & ~sck_p[2];
  wire sck_fall = ~sck_p[1] & sck_p[2];
  wire cs_rise  = cs_p[1] & ~cs_p[2];
  wire [7:0] rx_byte = {sh, mo_p[1]};
  wire burst = (cmd[5:1] == BURST_IDX);
  wire is_wr = cmd[0] & ~cmd[7];
  wire [NW-1:0] limit = !burst ? NW'(1) : (cmd[6] ? NW'(RAM_BYTES) : NW'(CLK_BURST));
  wire exh = (nbytes >= limit);
  wire [4:0] idx = burst ? nbytes[4:0] : cmd[5:1];
  wire data_done = active & sck_rise & (bcnt == 3'd7) & have_cmd;
  wire wr_byte = data_done & is_wr & ~exh;
  wire ram_we = wr_byte & cmd[6] & ~wp;
  wire clk_we = wr_byte & ~cmd[6] & ~burst & (~wp | (idx == 5'(CTRL_IDX)));
  wire buf_we = wr_byte & ~cmd[6] & burst;
  wire rp_go  = cs_rise & have_cmd & is_wr & burst & ~cmd[6] & (nbytes >= NW'(CLK_BURST));
  wire rp_wr  = rp_on & (~wp | (rp_idx == CW'(CTRL_IDX)));
  wire [7:0] rd_data = exh ? 8'h00 : (cmd[6] ? ram[idx] : reg_rdata);

  assign reg_rd_idx = idx;
  assign miso_en    = tx_on;
  assign miso       = tx_on ? tx[7] : 1'bz;

  always_ff @(posedge clk) begin
    if (ram_we) ram[idx] <= rx_byte;
    if (buf_we) cbuf[idx[CW-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1; sck_p <= '0; mo_p <= '0;
      bcnt <= '0; sh <= '0; cmd <= '0; tx <= '0; nbytes <= '0;
      have_cmd <= 1'b0; load <= 1'b0; skip <= 1'b0; tx_on <= 1'b0;
      wp <= 1'b0; rp_on <= 1'b0; rp_idx <= '0;
      reg_we <= 1'b0; reg_wr_idx <= '0; reg_wdata <= '0; byte_done <= 1'b0;
    end else begin
      cs_p  <= {cs_p[1:0], cs_n};
      sck_p <= {sck_p[1:0], sclk};
      mo_p  <= {mo_p[0], mosi};
      byte_done <= 1'b0;
      reg_we    <= 1'b0;
      load      <= 1'b0;
      if (!active) begin
        bcnt <= '0; sh <= '0; have_cmd <= 1'b0; tx_on <= 1'b0; skip <= 1'b0;
      end else begin
        if (sck_rise) begin
          sh   <= rx_byte[6:0];
          bcnt <= bcnt + 3'd1;
          if (bcnt == 3'd7) begin
            byte_done <= 1'b1;
            load      <= 1'b1;
            if (!have_cmd) begin
              cmd <= rx_byte; have_cmd <= 1'b1; nbytes <= '0;
            end else if (nbytes != '1) begin
              nbytes <= nbytes + 1'b1;
            end
          end
        end
        if (load) begin
          tx <= rd_data; tx_on <= cmd[7]; skip <= 1'b1;
        end else if (sck_fall) begin
          if (skip) skip <= 1'b0;
          else      tx <= {tx[6:0], 1'b0};
        end
      end
      if (clk_we) begin
        reg_we <= 1'b1; reg_wr_idx <= idx; reg_wdata <= rx_byte;
        if (idx == 5'(CTRL_IDX)) wp <= rx_byte[7];
      end
      if (rp_go) begin
        rp_on <= 1'b1; rp_idx <= '0;
      end else if (rp_on) begin
        rp_idx <= rp_idx + 1'b1;
        if (rp_idx == CW'(CLK_BURST - 1)) rp_on <= 1'b0;
        if (rp_wr) begin
          reg_we <= 1'b1; reg_wr_idx <= 5'(rp_idx); reg_wdata <= cbuf[rp_idx];
          if (rp_idx == CW'(CTRL_IDX)) wp <= cbuf[rp_idx][7];
        end
      end
    end
  end
endmodule

// File: rtl/rtc_spi_regport_chk.sv
module rtc_spi_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso_en,
  input logic       reg_we,
  input logic [4:0] reg_wr_idx,
  input logic       byte_done,
  input logic       wp,
  input logic [7:0] cmd
);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_en);

  assert_protect_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wr_idx != 5'd7) |-> !$past(wp));

  assert_lsb_gates_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (cmd[0] && !cmd[7]));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  assert_burst_in_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && $past(reg_we)) |-> (reg_wr_idx == $past(reg_wr_idx) + 5'd1));
endmodule

bind rtc_spi_regport rtc_spi_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_en(miso_en), .reg_we(reg_we),
  .reg_wr_idx(reg_wr_idx), .byte_done(byte_done), .wp(wp), .cmd(cmd)
);

// File: tb/rtc_spi_regport_bench.sv
module rtc_spi_regport_bench;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, mosi;
  wire  miso, miso_en, reg_we, byte_done;
  wire  [4:0] reg_rd_idx, reg_wr_idx;
  wire  [7:0] reg_wdata, reg_rdata;

  logic [7:0] ext_regs [32];
  logic [7:0] exp_regs [32];
  logic [7:0] exp_ram  [31];
  logic exp_wp;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int vectors = 0, fails = 0, we_cnt = 0, bd_cnt = 0, cs_hi = 0, we_delta = 0;
  logic drv_seen = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  assign reg_rdata = ext_regs[reg_rd_idx];

  rtc_spi_regport u_rtc_spi_regport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_en(miso_en), .reg_rd_idx(reg_rd_idx), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_wr_idx(reg_wr_idx), .reg_wdata(reg_wdata), .byte_done(byte_done)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin ext_regs[reg_wr_idx] = reg_wdata; we_cnt++; end
    if (byte_done) bd_cnt++;
    if (miso_en) drv_seen = 1'b1;
    if (cs_n) cs_hi++; else cs_hi = 0;
    if (cs_hi > 6) check("R8 idle enable", int'(miso_en), 0);
  end

  task automatic send_bit(input logic b, output logic r);
    mosi = b;
    repeat (8) @(negedge clk);
    r = miso_en ? miso : 1'b1;
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic run(input int extra);
    int bd0, we0;
    logic r;
    logic [7:0] b;
    bd0 = bd_cnt; we0 = we_cnt; drv_seen = 1'b0; rxq.delete();
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    foreach (txq[i]) begin
      b = '0;
      for (int k = 7; k >= 0; k--) begin send_bit(txq[i][k], r); b = {b[6:0], r}; end
      rxq.push_back(b);
    end
    for (int k = 0; k < extra; k++) send_bit(1'b1, r);
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R9 byte pulses", bd_cnt - bd0, txq.size());
    we_delta = we_cnt - we0;
    if (txq[0][7] == 1'b0) check("R8 no drive on write", int'(drv_seen), 0);
  endtask

  task automatic wr1(input logic [7:0] c, input logic [7:0] d);
    int expd;
    expd = 0;
    txq = '{c, d};
    run(0);
    if (c[0] && !c[7]) begin
      if (c[6]) begin
        if (!exp_wp) exp_ram[c[5:1]] = d;
      end else if (!exp_wp || c[5:1] == 5'd7) begin
        exp_regs[c[5:1]] = d; expd = 1;
        if (c[5:1] == 5'd7) exp_wp = d[7];
      end
    end
    check("R1 R3 R7 write strobes", we_delta, expd);
  endtask

  task automatic rd1(input logic [7:0] c);
    txq = '{c, 8'h00, 8'h00};
    run(0);
    check("R2 single read", rxq[1], c[6] ? exp_ram[c[5:1]] : exp_regs[c[5:1]]);
    check("R2 trailing zero", rxq[2], 0);
  endtask

  task automatic cmp_regs(input string tag);
    for (int i = 0; i < 32; i++) check(tag, ext_regs[i], exp_regs[i]);
  endtask

  task automatic clk_burst(input int nb, input int extra, input logic [7:0] ctrl);
    int expd;
    expd = 0;
    txq = '{8'h3F};
    for (int i = 0; i < nb; i++) txq.push_back((i == 7) ? ctrl : 8'(8'h11 * (i + 1) + 8'h03));
    run(extra);
    if (nb >= 8) begin
      for (int i = 0; i < 8; i++)
        if (!exp_wp || i == 7) begin
          exp_regs[i] = txq[i + 1]; expd++;
          if (i == 7) exp_wp = txq[8][7];
        end
    end
    check("R4 R7 burst strobes", we_delta, expd);
    cmp_regs("R4 register contents");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin ext_regs[i] = 8'(i * 5 + 2); exp_regs[i] = 8'(i * 5 + 2); end
    for (int i = 0; i < 31; i++) exp_ram[i] = 8'h00;
    exp_wp = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset miso_en", int'(miso_en), 0);
    check("R10 reset reg_we", int'(reg_we), 0);
    check("R10 reset byte_done", int'(byte_done), 0);

    wr1(8'h01, 8'h45);
    rd1(8'h81);
    wr1(8'h19, 8'h5A);
    rd1(8'h99);
    rd1(8'h93);
    cmp_regs("R1 register contents");

    wr1(8'h00, 8'h77);
    rd1(8'h81);

    txq = '{8'h7F};
    for (int i = 0; i < 31; i++) begin txq.push_back(8'(i * 7 + 3)); exp_ram[i] = 8'(i * 7 + 3); end
    run(0);
    check("R5 no register strobes", we_delta, 0);
    txq = '{8'hFF};
    for (int i = 0; i < 33; i++) txq.push_back(8'h00);
    run(0);
    for (int i = 0; i < 31; i++) check("R6 burst read byte", rxq[i + 1], exp_ram[i]);
    check("R6 past end zero", rxq[32], 0);
    check("R6 past end zero", rxq[33], 0);

    txq = '{8'h7F, 8'hA1, 8'hA2, 8'hA3};
    exp_ram[0] = 8'hA1; exp_ram[1] = 8'hA2; exp_ram[2] = 8'hA3;
    run(5);
    rd1(8'hC1);
    rd1(8'hC5);
    rd1(8'hC7);
    wr1(8'h45, 8'hEE);
    rd1(8'hC5);
    wr1(8'h44, 8'h11);
    rd1(8'hC5);

    clk_burst(8, 0, 8'h05);
    txq = '{8'hBF};
    for (int i = 0; i < 9; i++) txq.push_back(8'h00);
    run(0);
    for (int i = 0; i < 8; i++) check("R4 burst read order", rxq[i + 1], exp_regs[i]);
    check("R4 burst read end zero", rxq[9], 0);
    clk_burst(7, 4, 8'h06);

    wr1(8'h0F, 8'h80);
    wr1(8'h01, 8'h12);
    wr1(8'h4B, 8'h99);
    rd1(8'hCB);
    rd1(8'h81);
    clk_burst(8, 0, 8'h84);
    wr1(8'h0F, 8'h00);
    wr1(8'h01, 8'h12);
    rd1(8'h81);
    cmp_regs("R7 register contents");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule